// File: doc/BRIEF.md
# Programmable CRC Engine with Input FIFO

This block computes a 32-bit Galois-field remainder (CRC or general LFSR) over a stream of 32-bit words that software supplies through a simple register write port. Four consecutive word addresses are all data-input ports. Whichever of them is written, the word joins an eight-entry FIFO in the order the writes arrive. A back-end engine drains the FIFO and folds each word into the remainder eight bits per cycle. The polynomial comes from a writable register.

A control register sets three things. The first is the bit order: most-significant bit first with the polynomial used as written, or least-significant bit first with the polynomial bit-reversed. The other two turn on byte reversal of each word on the way in and on the way out. Writing the start address loads a seed into the remainder, discards any queued words and clears the sticky overflow flag. The result is read through four 32-bit output words that cover a 128-bit field. Word 0 holds the 32-bit remainder and the upper words read as zero.

Top module: `crc_fifo_engine`

## Requirements
- R1: A write to word address 0, 1, 2 or 3 queues the word. Words are folded into the remainder in write order, whichever of these addresses was used.
- R2: When control bit 1 (input swap) is set, each queued data word has its byte order reversed before it enters the FIFO.
- R3: The FIFO holds 8 words. A data write that finds it holding 8 words is dropped and sets the overflow output. The flag stays set until the next start.
- R4: The engine takes one word from a non-empty FIFO when idle and then spends 4 cycles on it. `busy` is high while the FIFO holds a word or a word is in progress, and low otherwise.
- R5: A write to address 7 (start) loads the seed register into the remainder, empties the FIFO and clears overflow.
- R6: With control bit 0 set (MSB-first), data bits are taken from bit 31 down to bit 0 and the remainder shifts left. The polynomial is applied as written.
- R7: With control bit 0 clear (LSB-first), data bits are taken from bit 0 up to bit 31 and the remainder shifts right. The bit-reversed polynomial is applied.
- R8: Read word 0 returns the remainder. Read words 1 to 3 return zero.
- R9: When control bit 2 (output swap) is set, read data has its byte order reversed.
- R10: Address 4 writes the polynomial (reset 0x04C11DB7), address 5 the seed (reset 0xFFFFFFFF) and address 6 the control bits (reset 0). After reset the remainder is 0, and `busy` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Output word select |
| rd_data | output | 32 | Selected output word |
| busy | output | 1 | FIFO non-empty or a word in progress |
| overflow | output | 1 | Sticky flag for a dropped data write |

## Verification
The bench goes after the full-FIFO boundary. Ten back-to-back writes from idle must all be kept, and an eleventh must be dropped and flagged. A design with an off-by-one depth check would either lose a word or corrupt the remainder. Randomized trials mix addresses, bit order and both swaps against a bench model of the reflected mode, which is written as a reversal of the plain mode. A design that forgets to reverse the polynomial, or that shifts data the wrong way, fails there. Directed checks cover the busy window of a single word, overflow that survives a drained FIFO, and a start that must both clear the flag and restore the seed.

// File: rtl/crc_fifo_pkg.sv
package crc_fifo_pkg;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic swap_out;
    logic swap_in;
    logic msb_first;
  } crc_ctrl_t;

  function automatic logic [WORD_W-1:0] byte_rev(input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < WORD_W/8; b++)
      r[8*b +: 8] = d[8*(WORD_W/8-1-b) +: 8];
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] bit_rev(input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++)
      r[i] = d[WORD_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/crc_in_fifo.sv
module crc_in_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty,
  output logic         full,
  output logic         overflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             push_ok, pop_ok, push_drop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (count == '0);
  assign full      = (count == CNT_FULL);
  assign push_ok   = push && !full;
  assign push_drop = push && full;
  assign pop_ok    = pop && !empty;
  assign pop_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else if (flush) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
      if (push_drop) overflow <= 1'b1;
    end
  end

  p_fifo_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_FULL);
  p_drop_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !flush) |=> overflow);
  p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !overflow));
  p_sticky_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !flush) |=> overflow);
endmodule

// File: rtl/crc_core.sv
module crc_core #(
  parameter int W    = 32,
  parameter int BITS = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] seed,
  input  logic [W-1:0] poly,
  input  logic         msb_first,
  input  logic         fifo_empty,
  input  logic [W-1:0] fifo_data,
  output logic         pop,
  output logic [W-1:0] rem,
  output logic         active
);
  import crc_fifo_pkg::*;

  localparam int STEPS = W / BITS;
  localparam int CNT_W = $clog2(STEPS + 1);

  logic [W-1:0]     shreg;
  logic [CNT_W-1:0] cnt;
  logic             word_msb;
  logic [BITS-1:0]  chunk;

  function automatic logic [W-1:0] fold_bits(input logic [W-1:0] r_in,
                                             input logic [BITS-1:0] c,
                                             input logic [W-1:0] p,
                                             input logic msb);
    logic [W-1:0] r;
    logic [W-1:0] rp;
    logic fb;
    r  = r_in;
    rp = bit_rev(p);
    if (msb) begin
      for (int i = BITS-1; i >= 0; i--) begin
        fb = r[W-1] ^ c[i];
        r  = {r[W-2:0], 1'b0} ^ (fb ? p : '0);
      end
    end else begin
      for (int i = 0; i < BITS; i++) begin
        fb = r[0] ^ c[i];
        r  = {1'b0, r[W-1:1]} ^ (fb ? rp : '0);
      end
    end
    return r;
  endfunction

  assign active = (cnt != '0);
  assign pop    = !active && !fifo_empty && !start;
  assign chunk  = word_msb ? shreg[W-1 -: BITS] : shreg[BITS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem      <= '0;
      shreg    <= '0;
      cnt      <= '0;
      word_msb <= 1'b0;
    end else if (start) begin
      rem <= seed;
      cnt <= '0;
    end else if (pop) begin
      shreg    <= fifo_data;
      cnt      <= CNT_W'(STEPS);
      word_msb <= msb_first;
    end else if (active) begin
      rem   <= fold_bits(rem, chunk, poly, word_msb);
      shreg <= word_msb ? (shreg << BITS) : (shreg >> BITS);
      cnt   <= cnt - 1'b1;
    end
  end

  p_seed_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (rem == $past(seed)) && !active);
  p_pop_starts_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> active);
  p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !pop && !start) |=> $stable(rem));
endmodule

// File: rtl/crc_fifo_engine.sv
module crc_fifo_engine #(
  parameter int          W          = 32,
  parameter int          FIFO_DEPTH = 8,
  parameter int          BITS       = 8,
  parameter logic [31:0] POLY_RESET = 32'h04C1_1DB7,
  parameter logic [31:0] SEED_RESET = 32'hFFFF_FFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [31:0]  wr_data,
  input  logic [1:0]   rd_addr,
  output logic [31:0]  rd_data,
  output logic         busy,
  output logic         overflow
);
  import crc_fifo_pkg::*;

  localparam logic [2:0] A_POLY  = 3'd4;
  localparam logic [2:0] A_SEED  = 3'd5;
  localparam logic [2:0] A_CTRL  = 3'd6;
  localparam logic [2:0] A_START = 3'd7;

  crc_ctrl_t    ctrl;
  logic [W-1:0] poly_q, seed_q, rem, fifo_out, push_word;
  logic         data_wr, start_wr, pop, fifo_empty, fifo_full, core_active;

  assign data_wr   = wr_en && !wr_addr[2];
  assign start_wr  = wr_en && (wr_addr == A_START);
  assign push_word = ctrl.swap_in ? byte_rev(wr_data) : wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poly_q <= POLY_RESET;
      seed_q <= SEED_RESET;
      ctrl   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_POLY:  poly_q <= wr_data;
        A_SEED:  seed_q <= wr_data;
        A_CTRL:  ctrl   <= crc_ctrl_t'(wr_data[2:0]);
        default: ;
      endcase
    end
  end

  crc_in_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (start_wr),
    .push      (data_wr),
    .push_data (push_word),
    .pop       (pop),
    .pop_data  (fifo_out),
    .empty     (fifo_empty),
    .full      (fifo_full),
    .overflow  (overflow)
  );

  crc_core #(.W(W), .BITS(BITS)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_wr),
    .seed       (seed_q),
    .poly       (poly_q),
    .msb_first  (ctrl.msb_first),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_out),
    .pop        (pop),
    .rem        (rem),
    .active     (core_active)
  );

  assign busy = !fifo_empty || core_active;

  always_comb begin
    if (rd_addr == 2'd0) rd_data = ctrl.swap_out ? byte_rev(rem) : rem;
    else                 rd_data = '0;
  end

  p_one_write_kind_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_wr, start_wr}));
  p_full_is_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> busy);
endmodule

// File: tb/tb_crc_fifo_engine.sv
module tb_crc_fifo_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        busy, overflow;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  crc_fifo_engine dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .overflow(overflow)
  );

  function automatic logic [31:0] bswap(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic logic [31:0] brev(input logic [31:0] d);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = d[i];
    return r;
  endfunction

  function automatic logic [31:0] ref_msb(input logic [31:0] r, input logic [31:0] d,
                                          input logic [31:0] p);
    logic [31:0] x;
    x = r;
    for (int i = 31; i >= 0; i--)
      x = x[31] ^ d[i] ? ((x << 1) ^ p) : (x << 1);
    return x;
  endfunction

  function automatic logic [31:0] ref_lsb(input logic [31:0] r, input logic [31:0] d,
                                          input logic [31:0] p);
    return brev(ref_msb(brev(r), brev(d), p));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
  endtask

  task automatic wr_done();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  logic [31:0] exp_rem;

  task automatic setup(input logic [2:0] c, input logic [31:0] p, input logic [31:0] s);
    wr(3'd6, {29'd0, c});
    wr(3'd4, p);
    wr(3'd5, s);
    wr(3'd7, 32'd0);
    wr_done();
    exp_rem = s;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, w, p;
    logic [2:0]  c;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 R8: reset state
    rd(2'd0, v); chk("R10 reset remainder", v, 32'd0);
    chk("R10 reset busy", {31'd0, busy}, 32'd0);
    chk("R10 reset overflow", {31'd0, overflow}, 32'd0);

    // R5: start loads reset seed
    wr(3'd7, 32'd0); wr_done();
    rd(2'd0, v); chk("R5 start loads reset seed", v, 32'hFFFF_FFFF);

    // R4: busy window for one word
    wr(3'd2, 32'h1234_5678); wr_done();
    chk("R4 busy after write", {31'd0, busy}, 32'd1);
    repeat (4) @(negedge clk);
    chk("R4 busy while folding", {31'd0, busy}, 32'd1);
    @(negedge clk);
    chk("R4 idle after four steps", {31'd0, busy}, 32'd0);
    rd(2'd0, v);
    chk("R7 reset poly LSB-first", v, ref_lsb(32'hFFFF_FFFF, 32'h1234_5678, 32'h04C1_1DB7));

    // R3: ten back-to-back writes fit, none dropped
    setup(3'b001, 32'h1EDC_6F41, 32'h0);
    for (int i = 0; i < 10; i++) begin
      w = $urandom;
      wr(3'(i % 4), w);
      exp_rem = ref_msb(exp_rem, w, 32'h1EDC_6F41);
    end
    wr_done();
    chk("R3 ten writes no overflow", {31'd0, overflow}, 32'd0);
    wait_idle();
    rd(2'd0, v); chk("R3 ten words all folded", v, exp_rem);

    // R3: eleventh write is dropped and flagged
    setup(3'b001, 32'h1EDC_6F41, 32'h0);
    for (int i = 0; i < 11; i++) begin
      w = $urandom;
      wr(3'd0, w);
      if (i < 10) exp_rem = ref_msb(exp_rem, w, 32'h1EDC_6F41);
    end
    wr_done();
    chk("R3 eleventh write flags overflow", {31'd0, overflow}, 32'd1);
    wait_idle();
    chk("R3 overflow sticky when drained", {31'd0, overflow}, 32'd1);
    rd(2'd0, v); chk("R3 dropped word not folded", v, exp_rem);

    // R5: start clears overflow and discards queued words
    wr(3'd5, 32'hA5A5_0F0F);
    for (int i = 0; i < 3; i++) wr(3'd1, $urandom);
    wr(3'd7, 32'd0); wr_done();
    chk("R5 start clears overflow", {31'd0, overflow}, 32'd0);
    chk("R5 start empties FIFO", {31'd0, busy}, 32'd0);
    rd(2'd0, v); chk("R5 start restores seed", v, 32'hA5A5_0F0F);

    // R1 R2 R6 R7 R8 R9: random trials
    for (int t = 0; t < 40; t++) begin
      int n;
      c = 3'($urandom);
      p = $urandom | 32'h1;
      setup(c, p, $urandom);
      n = 1 + ($urandom % 6);
      for (int k = 0; k < n; k++) begin
        logic [31:0] d;
        w = $urandom;
        wr(3'($urandom % 4), w);
        d = c[1] ? bswap(w) : w;
        exp_rem = c[0] ? ref_msb(exp_rem, d, p) : ref_lsb(exp_rem, d, p);
      end
      wr_done();
      wait_idle();
      rd(2'd0, v);
      if (c[0]) chk("R6 R1 R2 R9 MSB-first result", v, c[2] ? bswap(exp_rem) : exp_rem);
      else      chk("R7 R1 R2 R9 LSB-first result", v, c[2] ? bswap(exp_rem) : exp_rem);
      for (int a = 1; a < 4; a++) begin
        rd(2'(a), v); chk("R8 upper words zero", v, 32'd0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule